// File: doc/BRIEF.md
# JTAG Test Access Port with Auxiliary-TAP Handoff

This block is a boundary-scan test access port controller with a 5-bit instruction register. It runs the sixteen-state TAP state machine from TCK and TMS. It decodes the current instruction to choose a serial path between TDI and TDO: a one-bit bypass stage or a 32-bit identification register. It also drives a clamp-enable signal for the boundary cells and a system-reset request.

Two instruction codes hand the TAP pins to an auxiliary TAP controller. After such an instruction is loaded, the selected auxiliary port receives TMS and TDI, and its TDO is passed to the main TDO pin. The main state machine keeps following TMS while the auxiliary TAP has the pins. It takes the pins back at Update-DR of a data scan that went through Pause-DR, and at that point the instruction becomes bypass. The auxiliary TAP that is not selected sees TMS held low, so it rests in Run-Test/Idle. Test-Logic-Reset, or a low level on the TAP reset pin, cancels any handoff.

Top module: `tap_handoff_ctrl`

## Requirements
- R1: While the TAP reset pin is low, and whenever the state machine is in Test-Logic-Reset, the instruction becomes IDCODE (00001) and any auxiliary handoff ends.
- R2: In Capture-IR the instruction shift stage loads 00001, so the first five bits shifted out of TDO in an instruction scan are 1,0,0,0,0.
- R3: Under IDCODE (00001), Capture-DR loads the 32-bit identification value, which is then shifted out LSB first.
- R4: BYPASS (11111) selects a single stage that captures 0, so a data scan returns 0 followed by TDI delayed by one TCK.
- R5: Every code other than 00001, 10000, 10001 and 10010 is decoded as bypass. This includes the reserved codes 00010 to 00111, 01001, 01010 and 01100.
- R6: CLAMP (10000) uses the bypass stage as the serial path, and drives clamp_en and sys_rst_req high for as long as it is the current instruction.
- R7: After Update-IR loads 10001 (auxiliary port 0) or 10010 (auxiliary port 1), the selected port receives TMS and TDI and its TDO is driven on the main TDO pin.
- R8: Control returns to the main TAP only at Update-DR of a data scan that passed through Pause-DR, and the instruction then becomes BYPASS. A scan without Pause-DR leaves the handoff in place.
- R9: A port that is not selected has aux_tms held at 0 and aux_tdi held at 1.
- R10: TDO and tdo_oe change on the falling edge of TCK, and tdo_oe is high only in Shift-IR and Shift-DR.
- R11: While an auxiliary TAP has the pins, instruction scans do not change the main instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low TAP reset; asserts asynchronously, released on TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | TDO drive enable; low means high impedance |
| aux_tms | output | NAUX | TMS for each auxiliary TAP |
| aux_tdi | output | NAUX | TDI for each auxiliary TAP |
| aux_tdo | input | NAUX | TDO from each auxiliary TAP |
| sys_rst_req | output | 1 | System reset request, high under CLAMP |
| clamp_en | output | 1 | Holds boundary-cell outputs at their captured values |

## Verification
The assertions assume that TMS is held low in the TCK cycle after Update-IR of an access-auxiliary instruction. That keeps the state machine of the newly selected auxiliary TAP, which is resting in Run-Test/Idle, in step with the main one. They also assume that the auxiliary TDO inputs change only on falling TCK edges. The stimulus always returns to Run-Test/Idle with TMS low after each update state. The auxiliary TAP models in the bench update TDO on falling edges only. Instruction codes are drawn at random over all 32 values, and each handoff is closed with a paused data scan before the next draw.

// File: rtl/tapho_pkg.sv
package tapho_pkg;

  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_IDCODE   = 5'b00001;
  localparam logic [IR_W-1:0] OP_CLAMP    = 5'b10000;
  localparam logic [IR_W-1:0] OP_AUX_BASE = 5'b10001;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 5'b00001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = m ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   n = m ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: n = m ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: n = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: n = m ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   n = m ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   n = m ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: n = m ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: n = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: n = m ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     n = m ? ST_DR_SEL   : ST_IDLE;
    endcase
    return n;
  endfunction

  // True when the code selects one of the first naux auxiliary ports.
  function automatic logic is_aux_code(input logic [IR_W-1:0] c, input int naux);
    return (int'(c) >= int'(OP_AUX_BASE)) && (int'(c) < int'(OP_AUX_BASE) + naux);
  endfunction

endpackage

// File: rtl/tapho_rst_sync.sv
module tapho_rst_sync (
  input  logic tck,
  input  logic trst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/tapho_fsm.sv
module tapho_fsm
  import tapho_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_o
);
  tap_state_e st_q, st_d;

  always_comb st_d = tap_next(st_q, tms);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // Five TMS ones always end in reset; from reset, TMS high must stay there.
  assert_reset_hold_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (st_q == ST_RESET && tms) |=> (st_q == ST_RESET));
endmodule

// File: rtl/tapho_ir.sv
module tapho_ir
  import tapho_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic            hold_i,
  input  logic            release_i,
  output logic [IR_W-1:0] ir_o,
  output logic [IR_W-1:0] ir_shift_o,
  output logic            ir_lsb_o
);
  logic [IR_W-1:0] sh_q, sh_d, ir_q, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    if (!hold_i) begin
      if (state == ST_IR_CAP) begin
        sh_en = 1'b1;
        sh_d  = IR_CAPTURE;
      end else if (state == ST_IR_SHIFT) begin
        sh_en = 1'b1;
        sh_d  = {tdi, sh_q[IR_W-1:1]};
      end
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == ST_RESET) begin
      ir_en = 1'b1;
      ir_d  = OP_IDCODE;
    end else if (release_i) begin
      ir_en = 1'b1;
      ir_d  = OP_BYPASS;
    end else if (state == ST_IR_UPD && !hold_i) begin
      ir_en = 1'b1;
      ir_d  = sh_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAPTURE;
      ir_q <= OP_IDCODE;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir_o       = ir_q;
  assign ir_shift_o = sh_q;
  assign ir_lsb_o   = sh_q[0];

  assert_ir_reset_idcode_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |=> (ir_q == OP_IDCODE));

  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(state == ST_IR_CAP && !hold_i)) |-> (sh_q == IR_CAPTURE));

  assert_ir_locked_R11: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(hold_i && state == ST_IR_UPD)) |-> $stable(ir_q));
endmodule

// File: rtl/tapho_dr.sv
module tapho_dr
  import tapho_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h5C3A_104D
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       sel_id_i,
  output logic       dr_lsb_o
);
  logic            byp_q, byp_d, byp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;

  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_q;
    id_en  = 1'b0;
    id_d   = id_q;
    if (state == ST_DR_CAP) begin
      byp_en = 1'b1;
      byp_d  = 1'b0;
      id_en  = sel_id_i;
      id_d   = ID_VALUE[ID_W-1:0];
    end else if (state == ST_DR_SHIFT) begin
      byp_en = !sel_id_i;
      byp_d  = tdi;
      id_en  = sel_id_i;
      id_d   = {tdi, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      if (byp_en) byp_q <= byp_d;
      if (id_en)  id_q  <= id_d;
    end
  end

  assign dr_lsb_o = sel_id_i ? id_q[0] : byp_q;

  assert_bypass_capture_R4: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(state == ST_DR_CAP)) |-> (byp_q == 1'b0));
endmodule

// File: rtl/tap_handoff_ctrl.sv
module tap_handoff_ctrl
  import tapho_pkg::*;
#(
  parameter int          NAUX     = 2,
  parameter logic [31:0] ID_VALUE = 32'h5C3A_104D
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [NAUX-1:0] aux_tms,
  output logic [NAUX-1:0] aux_tdi,
  input  logic [NAUX-1:0] aux_tdo,
  output logic            sys_rst_req,
  output logic            clamp_en
);
  localparam int AUX_IW = (NAUX > 1) ? $clog2(NAUX) : 1;

  logic              rst_n;
  tap_state_e        state;
  logic [IR_W-1:0]   ir_q, ir_shift;
  logic              ir_lsb, dr_lsb;
  logic              owned, release_now;
  logic [AUX_IW-1:0] aux_sel;
  logic              paused_q, paused_d, paused_en;
  logic              shift_any, tdo_q, oe_q;

  tapho_rst_sync u_sync (.tck(tck), .trst_n(trst_n), .rst_n_o(rst_n));

  tapho_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state_o(state));

  // Ownership is carried by the instruction itself: an auxiliary code in the
  // instruction register means the pins belong to that auxiliary TAP.
  assign owned   = is_aux_code(ir_q, NAUX);
  assign aux_sel = AUX_IW'(ir_q - OP_AUX_BASE);

  assign release_now = owned && (state == ST_DR_UPD) && paused_q;

  tapho_ir u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .hold_i(owned), .release_i(release_now),
    .ir_o(ir_q), .ir_shift_o(ir_shift), .ir_lsb_o(ir_lsb)
  );

  tapho_dr #(.ID_W(32), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .sel_id_i(ir_q == OP_IDCODE), .dr_lsb_o(dr_lsb)
  );

  // Pause-DR seen since the last Capture-DR.
  always_comb begin
    paused_en = 1'b0;
    paused_d  = paused_q;
    if (state == ST_DR_CAP || state == ST_RESET) begin
      paused_en = 1'b1;
      paused_d  = 1'b0;
    end else if (state == ST_DR_PAUSE) begin
      paused_en = 1'b1;
      paused_d  = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         paused_q <= 1'b0;
    else if (paused_en) paused_q <= paused_d;
  end

  // Serial output retimed to the falling edge.
  assign shift_any = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= shift_any;
      if (shift_any) tdo_q <= (state == ST_IR_SHIFT) ? ir_lsb : dr_lsb;
    end
  end

  assign tdo    = owned ? aux_tdo[aux_sel] : tdo_q;
  assign tdo_oe = oe_q;

  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    logic pick;
    assign pick       = owned && (aux_sel == AUX_IW'(g));
    assign aux_tms[g] = pick ? tms : 1'b0;
    assign aux_tdi[g] = pick ? tdi : 1'b1;
  end

  assign clamp_en    = (ir_q == OP_CLAMP);
  assign sys_rst_req = clamp_en;

  assert_take_at_update_ir_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (owned && !$past(owned)) |-> ($past(state == ST_IR_UPD) && is_aux_code($past(ir_shift), NAUX)));

  assert_return_after_pause_R8: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(owned) && !owned && $past(state) != ST_RESET)
      |-> ($past(state == ST_DR_UPD) && $past(paused_q)));

  assert_idle_aux_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (!owned) |-> (aux_tms == '0 && aux_tdi == '1));

  assert_oe_shift_R10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

  assert_clamp_reset_R6: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(state == ST_IR_UPD && ir_shift == OP_CLAMP && !owned)) |-> (clamp_en && sys_rst_req));
endmodule

// File: tb/tap_handoff_ctrl_test.sv
module aux_tap_model #(
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic [3:0] st
);
  // Plain shift-register auxiliary TAP: data shifted in comes out next scan.
  logic [7:0] sr;

  function automatic logic [3:0] nx(input logic [3:0] s, input logic m);
    case (s)
      4'd0:  return m ? 4'd0  : 4'd1;
      4'd1:  return m ? 4'd2  : 4'd1;
      4'd2:  return m ? 4'd9  : 4'd3;
      4'd3:  return m ? 4'd5  : 4'd4;
      4'd4:  return m ? 4'd5  : 4'd4;
      4'd5:  return m ? 4'd8  : 4'd6;
      4'd6:  return m ? 4'd7  : 4'd6;
      4'd7:  return m ? 4'd8  : 4'd4;
      4'd8:  return m ? 4'd2  : 4'd1;
      4'd9:  return m ? 4'd0  : 4'd10;
      4'd10: return m ? 4'd12 : 4'd11;
      4'd11: return m ? 4'd12 : 4'd11;
      4'd12: return m ? 4'd15 : 4'd13;
      4'd13: return m ? 4'd14 : 4'd13;
      4'd14: return m ? 4'd15 : 4'd11;
      default: return m ? 4'd2 : 4'd1;
    endcase
  endfunction

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      st <= 4'd0;
      sr <= INIT;
    end else begin
      if (st == 4'd4) sr <= {tdi, sr[7:1]};
      st <= nx(st, tms);
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo <= 1'b0;
    else if (st == 4'd4) tdo <= sr[0];
    else if (st == 4'd11) tdo <= 1'b1;
  end
endmodule

module tap_handoff_ctrl_test;
  localparam logic [31:0] IDV = 32'h5C3A_104D;
  localparam logic [3:0]  AUX_IDLE = 4'd1;

  logic       tck = 1'b0;
  logic       trst_n, tms, tdi;
  logic       tdo, tdo_oe, sys_rst_req, clamp_en;
  logic [1:0] aux_tms, aux_tdi, aux_tdo;
  logic [3:0] st0, st1;

  int checks = 0;
  int failures = 0;
  logic [7:0] shadow [2];

  always #10 tck = ~tck;

  tap_handoff_ctrl #(.NAUX(2), .ID_VALUE(IDV)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .aux_tms(aux_tms), .aux_tdi(aux_tdi), .aux_tdo(aux_tdo),
    .sys_rst_req(sys_rst_req), .clamp_en(clamp_en)
  );

  aux_tap_model #(.INIT(8'hA5)) u_aux0 (.tck(tck), .rst_n(trst_n), .tms(aux_tms[0]),
    .tdi(aux_tdi[0]), .tdo(aux_tdo[0]), .st(st0));
  aux_tap_model #(.INIT(8'h3C)) u_aux1 (.tck(tck), .rst_n(trst_n), .tms(aux_tms[1]),
    .tdi(aux_tdi[1]), .tdo(aux_tdo[1]), .st(st1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic reset_tap();
    trst_n = 1'b0;
    repeat (3) tick(1'b1, 1'b0);
    trst_n = 1'b1;
    repeat (3) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    shadow[0] = 8'hA5;
    shadow[1] = 8'h3C;
  endtask

  task automatic ir_scan(input logic [4:0] code, output logic [4:0] cap);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      cap[i] = tdo;
      tick(i == 4, code[i]);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, input logic pause,
                         output logic [63:0] dout);
    dout = '0;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    if (pause) begin
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
      tick(1'b1, 1'b0);
    end else begin
      tick(1'b1, 1'b0);
    end
    tick(1'b0, 1'b0);
  endtask

  function automatic int classify(input logic [4:0] c);
    if (c == 5'b00001) return 0;
    if (c == 5'b10000) return 2;
    if (c == 5'b10001) return 3;
    if (c == 5'b10010) return 4;
    return 1;
  endfunction

  function automatic logic [63:0] byp_exp(input int n, input logic [63:0] d);
    logic [63:0] e = {d[62:0], 1'b0};
    return e & ((64'd1 << n) - 64'd1);
  endfunction

  task automatic bypass_check(input string req);
    logic [63:0] d, o;
    int n;
    n = 1 + ($urandom % 40);
    d = {$urandom, $urandom};
    dr_scan(n, d, 1'b0, o);
    chk(req, o, byp_exp(n, d));
  endtask

  task automatic aux_scan(input int idx, input logic pause, input string req);
    logic [63:0] d, o;
    d = 64'($urandom % 256);
    dr_scan(8, d, pause, o);
    chk(req, o, 64'(shadow[idx]));
    shadow[idx] = d[7:0];
  endtask

  initial begin : watchdog
    #(20 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [4:0]  cap;
    logic [63:0] o;
    void'($urandom(32'd1149));
    tms = 1'b1;
    tdi = 1'b0;
    reset_tap();

    // R1 reset state and IDCODE after reset
    chk("R1 clamp_en after reset", 64'(clamp_en), 64'd0);
    chk("R9 idle aux pins", 64'({aux_tms, aux_tdi}), 64'b0011);
    chk("R10 tdo_oe in idle", 64'(tdo_oe), 64'd0);
    dr_scan(32, 64'd0, 1'b0, o);
    chk("R3 IDCODE after reset (R1)", o, 64'(IDV));

    // R2 capture value; R4 bypass
    ir_scan(5'b11111, cap);
    chk("R2 capture-IR bits", 64'(cap), 64'd1);
    bypass_check("R4 bypass scan");

    // R10 falling-edge timing on entry to Shift-DR
    tms = 1'b1; @(posedge tck); @(negedge tck);
    tms = 1'b0; @(posedge tck); @(negedge tck);
    @(posedge tck); #1;
    chk("R10 oe low before falling edge", 64'(tdo_oe), 64'd0);
    @(negedge tck); #1;
    chk("R10 oe high after falling edge", 64'(tdo_oe), 64'd1);
    chk("R10 bypass captured 0 on tdo", 64'(tdo), 64'd0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R10 oe low after scan", 64'(tdo_oe), 64'd0);

    // R5 reserved codes
    ir_scan(5'b01100, cap);
    bypass_check("R5 reserved 01100");
    ir_scan(5'b00101, cap);
    bypass_check("R5 reserved 00101");

    // R6 clamp
    ir_scan(5'b10000, cap);
    chk("R6 clamp_en", 64'(clamp_en), 64'd1);
    chk("R6 sys_rst_req", 64'(sys_rst_req), 64'd1);
    bypass_check("R6 clamp bypass path");

    // R7/R8/R11 handoff to aux 0
    ir_scan(5'b10001, cap);
    chk("R6 clamp released", 64'(clamp_en), 64'd0);
    chk("R9 aux1 idle while aux0 owns", 64'(st1), 64'(AUX_IDLE));
    aux_scan(0, 1'b0, "R7 aux0 data on tdo");
    aux_scan(0, 1'b0, "R8 no pause keeps aux0");
    ir_scan(5'b00001, cap);
    aux_scan(0, 1'b0, "R11 IR scan while owned");
    chk("R9 aux1 tms low", 64'(aux_tms[1]), 64'd0);
    aux_scan(0, 1'b1, "R8 paused scan through aux0");
    bypass_check("R8 bypass after return");
    chk("R9 aux0 idle after return", 64'(st0), 64'(AUX_IDLE));

    // R1 TMS reset cancels handoff of aux 1
    ir_scan(5'b10010, cap);
    aux_scan(1, 1'b0, "R7 aux1 data on tdo");
    repeat (5) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    dr_scan(32, 64'd0, 1'b0, o);
    chk("R1 TLR cancels handoff", o, 64'(IDV));
    chk("R9 aux1 idle after TLR", 64'(st1), 64'(AUX_IDLE));

    // R1 TRST cancels handoff
    ir_scan(5'b10001, cap);
    reset_tap();
    dr_scan(32, 64'd0, 1'b0, o);
    chk("R1 TRST cancels handoff", o, 64'(IDV));

    // Random instruction codes
    for (int k = 0; k < 24; k++) begin
      logic [4:0] code;
      int cls;
      code = 5'($urandom % 32);
      cls = classify(code);
      ir_scan(code, cap);
      chk("R2 capture-IR random", 64'(cap), 64'd1);
      chk("R6 clamp_en follows code", 64'(clamp_en), 64'(cls == 2));
      if (cls == 0) begin
        dr_scan(32, {$urandom, $urandom}, 1'b0, o);
        chk("R3 IDCODE random", o, 64'(IDV));
      end else if (cls == 3 || cls == 4) begin
        chk("R9 other aux idle", 64'((cls == 3) ? st1 : st0), 64'(AUX_IDLE));
        aux_scan(cls - 3, 1'b1, "R7 random aux scan");
        bypass_check("R8 random return to bypass");
      end else if (code == 5'b11111) begin
        bypass_check("R4 bypass random");
      end else begin
        bypass_check("R5 undefined code as bypass");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule